// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block keeps per-direction traffic statistics for an Ethernet port. At the end of each received or transmitted frame, the frame logic raises a one-cycle strobe. The strobe carries the frame length, FCS included, and a small set of status flags. The block turns each strobe into counter increments: byte and frame totals, per-category event counts, a receive error for frames longer than a programmed limit, and a seven-bin frame-size histogram for each direction.

Software or a management engine reads the counters through a simple read port. Data returns one cycle after the request.
- **Narrow counters** clear when they are read.
- **Wide counters** (byte and frame totals) are read in two steps. The low word is read first. That read captures the upper bits into a holding register and restarts the counter. A later read of the high word returns the captured bits, so the two halves always belong to the same value.

All counters stop at all ones instead of wrapping. A single clear input zeroes the whole bank.

Top module: `eth_stat_bank`

## Requirements
- R1: After reset every counter and the holding register read as zero.
- R2: Each rx_end adds rx_len to the RX byte counter (WIDE_W bits, default 45) and 1 to the RX frame counter. Each tx_end does the same to the TX pair. The wide counters sit at addresses 0/1 (RX bytes), 2/3 (RX frames), 4/5 (TX bytes) and 6/7 (TX frames). The even address is the low 32 bits and the odd address is the upper WIDE_W-32 bits, zero-extended.
- R3: A read of a wide low word does three things: it returns bits 31:0, it stores the upper bits in the single holding register, and it restarts that counter. A read of any wide high address returns the holding register, whatever the counter has done since.
- R4: Reading a narrow counter (NARROW_W bits, default 32, at address 8+index) returns its value and clears it.
- R5: rx_flags bit meanings:
  - bit 0: multicast
  - bit 1: broadcast
  - bit 2: FCS error
  - bit 3: pause
  - bit 4: jabber
  - bit 5: short
  - bit 6: symbol error
  - bit 7: oversize

  Bit k set on rx_end increments narrow index k.
- R6: An RX frame with rx_len > rx_max_len + 4 increments narrow index 8 (the limit excludes the 4 FCS bytes). This counter is independent of the oversize flag.
- R7: Each frame increments exactly one size bin, or none when it is shorter than 64 bytes. The bins are:

  | Bin | Length (bytes) |
  |-----|----------------|
  | 0 | exactly 64 |
  | 1 | 65..127 |
  | 2 | 128..255 |
  | 3 | 256..511 |
  | 4 | 512..1023 |
  | 5 | 1024..1518 |
  | 6 | 1519 and longer |

  RX bins are narrow indices 9..15. TX bins are narrow indices 20..26.
- R8: tx_flags bit meanings: bit 0 multicast, bit 1 broadcast, bit 2 pause, bit 3 any transmit error. Bit k set on tx_end increments narrow index 16+k.
- R9: A cycle with clr_all high zeroes every counter and the holding register, and drops any increment from that cycle.
- R10: A counter at all ones stays at all ones on further increments.
- R11: An increment in the same cycle as the clearing read of that counter leaves the counter at the increment amount, not zero.
- R12: A read of an address above 34 returns zero and changes no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Zero all statistics |
| rx_end | input | 1 | End-of-frame strobe, receive |
| rx_len | input | LEN_W | Receive frame length in bytes, FCS included |
| rx_flags | input | 8 | Receive status flags (R5) |
| rx_max_len | input | LEN_W | Maximum packet size, FCS excluded |
| tx_end | input | 1 | End-of-frame strobe, transmit |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 4 | Transmit status flags (R8) |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
Most internal faults here surface only when software reads a counter. A misrouted increment or a wrong bin boundary shows up on the first read of the affected address, one cycle after the request, as a count one off from the bench's tally. A counter that fails to clear on read is caught by the second read of the same address. A stale or missing holding-register capture appears as a wrong high word after a low read that followed more than 2^32 bytes. A saturation fault shows up as a small value after the histogram is driven past its width.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;
    localparam int N_WIDE      = 4;
    localparam int N_BKT       = 7;
    localparam int N_RXF       = 8;
    localparam int N_TXF       = 4;
    localparam int IX_RX_MAX   = N_RXF;
    localparam int IX_RX_BKT   = N_RXF + 1;
    localparam int IX_TX_FLG   = IX_RX_BKT + N_BKT;
    localparam int IX_TX_BKT   = IX_TX_FLG + N_TXF;
    localparam int N_NARROW    = IX_TX_BKT + N_BKT;
    localparam int NARROW_BASE = 2 * N_WIDE;
    localparam int LAST_ADDR   = NARROW_BASE + N_NARROW - 1;
    localparam int FCS_BYTES   = 4;
endpackage

// File: rtl/stat_cnt.sv
module stat_cnt #(
    parameter int W  = 32,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd_clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  cnt
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] base;
    logic [W:0]   sum;

    always_comb begin
        base = rd_clr ? '0 : cnt_q;
        sum  = {1'b0, base} + (W+1)'(inc);
        if (clr)
            cnt_d = '0;
        else if (sum[W])
            cnt_d = '1;
        else
            cnt_d = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rd_clr && cnt_q == '1) |=> cnt_q == '1);
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rd_clr) |=> cnt_q >= $past(cnt_q));
    a_r11_keep_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rd_clr) |=> cnt_q == W'($past(inc)));
endmodule

// File: rtl/size_bucket.sv
module size_bucket #(
    parameter int LEN_W = 16,
    parameter int NB    = 7
) (
    input  logic [LEN_W-1:0] len,
    output logic [NB-1:0]    hit
);
    logic [LEN_W:0] l;

    always_comb begin
        l   = {1'b0, len};
        hit = '0;
        if (l == (LEN_W+1)'(64))        hit[0] = 1'b1;
        else if (l < (LEN_W+1)'(64))    hit = '0;
        else if (l < (LEN_W+1)'(128))   hit[1] = 1'b1;
        else if (l < (LEN_W+1)'(256))   hit[2] = 1'b1;
        else if (l < (LEN_W+1)'(512))   hit[3] = 1'b1;
        else if (l < (LEN_W+1)'(1024))  hit[4] = 1'b1;
        else if (l < (LEN_W+1)'(1519))  hit[5] = 1'b1;
        else                            hit[NB-1] = 1'b1;
    end
endmodule

// File: rtl/eth_stat_bank.sv
module eth_stat_bank
    import eth_stat_pkg::*;
#(
    parameter int NARROW_W = 32,
    parameter int WIDE_W   = 45,
    parameter int LEN_W    = 16,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              rx_end,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [N_RXF-1:0]  rx_flags,
    input  logic [LEN_W-1:0]  rx_max_len,
    input  logic              tx_end,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [N_TXF-1:0]  tx_flags,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int HI_W = WIDE_W - 32;

    typedef struct packed {
        logic [31:0]     data;
        logic [HI_W-1:0] hold;
    } rd_state_t;

    rd_state_t r_d, r_q;

    logic [N_BKT-1:0]    rx_bkt, tx_bkt;
    logic [N_NARROW-1:0] n_inc, n_rdclr;
    logic [N_WIDE-1:0]   w_rdclr;
    logic [LEN_W-1:0]    w_inc [N_WIDE];
    logic [NARROW_W-1:0] n_cnt [N_NARROW];
    logic [WIDE_W-1:0]   w_cnt [N_WIDE];
    logic                rx_toolong;

    size_bucket #(.LEN_W(LEN_W), .NB(N_BKT)) u_rx_bkt (.len(rx_len), .hit(rx_bkt));
    size_bucket #(.LEN_W(LEN_W), .NB(N_BKT)) u_tx_bkt (.len(tx_len), .hit(tx_bkt));

    always_comb begin
        rx_toolong = {1'b0, rx_len} > ({1'b0, rx_max_len} + (LEN_W+1)'(FCS_BYTES));
        n_inc = '0;
        for (int k = 0; k < N_RXF; k++) n_inc[k] = rx_end & rx_flags[k];
        n_inc[IX_RX_MAX] = rx_end & rx_toolong;
        for (int k = 0; k < N_BKT; k++) begin
            n_inc[IX_RX_BKT+k] = rx_end & rx_bkt[k];
            n_inc[IX_TX_BKT+k] = tx_end & tx_bkt[k];
        end
        for (int k = 0; k < N_TXF; k++) n_inc[IX_TX_FLG+k] = tx_end & tx_flags[k];
        w_inc[0] = rx_end ? rx_len : '0;
        w_inc[1] = LEN_W'(rx_end);
        w_inc[2] = tx_end ? tx_len : '0;
        w_inc[3] = LEN_W'(tx_end);
    end

    always_comb begin
        r_d     = r_q;
        w_rdclr = '0;
        n_rdclr = '0;
        if (rd_en) begin
            r_d.data = '0;
            for (int k = 0; k < N_WIDE; k++) begin
                if (rd_addr == ADDR_W'(2*k)) begin
                    r_d.data   = w_cnt[k][31:0];
                    r_d.hold   = w_cnt[k][WIDE_W-1:32];
                    w_rdclr[k] = 1'b1;
                end
                if (rd_addr == ADDR_W'(2*k+1)) r_d.data = 32'(r_q.hold);
            end
            for (int j = 0; j < N_NARROW; j++) begin
                if (rd_addr == ADDR_W'(NARROW_BASE + j)) begin
                    r_d.data   = 32'(n_cnt[j]);
                    n_rdclr[j] = 1'b1;
                end
            end
        end
        if (clr_all) r_d.hold = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.data;

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        stat_cnt #(.W(WIDE_W), .IW(LEN_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .rd_clr(w_rdclr[g]),
            .inc(w_inc[g]), .cnt(w_cnt[g]));
    end

    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
        stat_cnt #(.W(NARROW_W), .IW(1)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr_all), .rd_clr(n_rdclr[g]),
            .inc(n_inc[g]), .cnt(n_cnt[g]));
    end

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > ADDR_W'(LAST_ADDR)) |=> rd_data == '0);
    a_r3_high_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr < ADDR_W'(NARROW_BASE) && rd_addr[0]) |=> rd_data[31:HI_W] == '0);
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !(rd_en && rd_addr < ADDR_W'(NARROW_BASE) && !rd_addr[0])) |=> $stable(r_q.hold));
    a_r7_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_bkt) && $onehot0(tx_bkt));
endmodule

// File: tb/sim_eth_stat_bank.sv
`timescale 1ns/1ps
module sim_eth_stat_bank;
    localparam int NW = 8;
    localparam int LW = 16;

    logic clk = 0, rst_n = 0, clr_all = 0;
    logic rx_end = 0, tx_end = 0, rd_en = 0;
    logic [LW-1:0] rx_len = 0, tx_len = 0, rx_max_len = 16'd1518;
    logic [7:0] rx_flags = 0;
    logic [3:0] tx_flags = 0;
    logic [5:0] rd_addr = 0;
    logic [31:0] rd_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    eth_stat_bank #(.NARROW_W(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .rx_end(rx_end), .rx_len(rx_len), .rx_flags(rx_flags), .rx_max_len(rx_max_len),
        .tx_end(tx_end), .tx_len(tx_len), .tx_flags(tx_flags),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic check(string req, string what, longint got, longint exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk); rd_en = 1; rd_addr = 6'(a);
        @(negedge clk); rd_en = 0; v = rd_data;
    endtask

    task automatic rd_chk(string req, int a, longint exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("addr %0d", a), longint'(v), exp);
    endtask

    task automatic rx(int len, logic [7:0] fl);
        @(negedge clk); rx_end = 1; rx_len = LW'(len); rx_flags = fl;
        @(negedge clk); rx_end = 0; rx_flags = 0;
    endtask

    task automatic tx(int len, logic [3:0] fl);
        @(negedge clk); tx_end = 1; tx_len = LW'(len); tx_flags = fl;
        @(negedge clk); tx_end = 0; tx_flags = 0;
    endtask

    task automatic drain();
        logic [31:0] v;
        for (int a = 0; a < 35; a++) rd(a, v);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 35; a += 3) rd_chk("R1", a, 0);
        rd_chk("R1", 1, 0);
    endtask

    task automatic t_rx_totals();
        drain();
        rx(100, 0); rx(200, 0); rx(1500, 0);
        rd_chk("R2", 0, 1800); rd_chk("R2", 1, 0);
        rd_chk("R2", 2, 3);    rd_chk("R2", 3, 0);
    endtask

    task automatic t_rx_flags();
        drain();
        rx(64, 8'b1010_0101);
        rd_chk("R5", 8, 1);  rd_chk("R5", 9, 0);  rd_chk("R5", 10, 1);
        rd_chk("R5", 11, 0); rd_chk("R5", 12, 0); rd_chk("R5", 13, 1);
        rd_chk("R5", 14, 0); rd_chk("R5", 15, 1); rd_chk("R7", 17, 1);
    endtask

    task automatic t_maxlen();
        drain();
        rx(1522, 0);
        rd_chk("R6", 16, 0);
        rx(1523, 0);
        rd_chk("R6", 16, 1);
        rd_chk("R6", 15, 0);
    endtask

    task automatic t_buckets();
        int lens[13] = '{63, 64, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9000};
        drain();
        foreach (lens[i]) rx(lens[i], 0);
        rd_chk("R7", 17, 1); rd_chk("R7", 18, 1); rd_chk("R7", 19, 2);
        rd_chk("R7", 20, 2); rd_chk("R7", 21, 2); rd_chk("R7", 22, 2);
        rd_chk("R7", 23, 2);
    endtask

    task automatic t_tx();
        drain();
        tx(80, 4'b1001); tx(2000, 4'b0110);
        rd_chk("R8", 4, 2080); rd_chk("R8", 6, 2);
        rd_chk("R8", 24, 1); rd_chk("R8", 25, 1); rd_chk("R8", 26, 1); rd_chk("R8", 27, 1);
        rd_chk("R8", 29, 1); rd_chk("R8", 34, 1); rd_chk("R8", 17, 0);
    endtask

    task automatic t_cor();
        drain();
        rx(70, 8'h01); rx(70, 8'h01);
        rd_chk("R4", 8, 2); rd_chk("R4", 8, 0);
    endtask

    task automatic t_same_cycle();
        drain();
        rx(70, 8'h01); rx(70, 8'h01);
        @(negedge clk); rd_en = 1; rd_addr = 6'd8; rx_end = 1; rx_len = 70; rx_flags = 8'h01;
        @(negedge clk); rd_en = 0; rx_end = 0; rx_flags = 0;
        check("R11", "read value", longint'(rd_data), 2);
        rd_chk("R11", 8, 1);
    endtask

    task automatic t_big();
        longint nfr = 65540;
        longint bytes = nfr * 65535;
        drain();
        @(negedge clk); rx_end = 1; rx_len = 16'hFFFF;
        repeat (65540) @(negedge clk);
        rx_end = 0;
        rd_chk("R2", 0, bytes & 64'hFFFF_FFFF);
        rx(10, 0);
        rd_chk("R3", 1, bytes >> 32);
        rd_chk("R3", 0, 10);
        rd_chk("R2", 2, (nfr + 1) & 64'hFFFF_FFFF);
        rd_chk("R3", 3, 0);
        rd_chk("R10", 23, 255);
    endtask

    task automatic t_clr();
        drain();
        rx(300, 8'hFF); tx(300, 4'hF);
        @(negedge clk); clr_all = 1; rx_end = 1; rx_len = 64; rx_flags = 8'h01;
        @(negedge clk); clr_all = 0; rx_end = 0; rx_flags = 0;
        rd_chk("R9", 0, 0); rd_chk("R9", 8, 0); rd_chk("R9", 20, 0);
        rd_chk("R9", 27, 0); rd_chk("R9", 17, 0);
    endtask

    task automatic t_unmapped();
        drain();
        rx(64, 8'h01);
        rd_chk("R12", 40, 0); rd_chk("R12", 63, 0);
        rd_chk("R12", 8, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_rx_totals(); t_rx_flags(); t_maxlen(); t_buckets();
        t_tx(); t_cor(); t_same_cycle(); t_clr(); t_unmapped(); t_big();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule